// File: doc/BRIEF.md
# Reconfigurable Self-Test Register

This block is an N-bit register bank that stands in place of a group of ordinary flip-flops inside a larger design. A two-bit mode input picks, cycle by cycle, what the bank does at the next clock edge. It can act as plain storage loading its parallel input. It can run on its own as a linear feedback shift register that produces a repeatable pseudo-random sequence. It can fold a stream of parallel response words into a single signature. It can also form one serial shift chain from a scan input to a scan output.

The feedback polynomial is fixed at build time through a tap parameter. The polynomial is x^WIDTH + (sum of TAPS[i]·x^i for i in 1..WIDTH-1) + 1, and it must be primitive. A primitive polynomial gives a sequence of maximal length 2^WIDTH − 1. The shift direction is from bit 0 toward bit WIDTH-1. In both feedback modes the next state is the current state multiplied by x modulo that polynomial. A signature built in the folding mode is read out afterwards by switching to the scan mode and shifting it out of the last stage.

Top module: `bistreg_top`

## Requirements
- R1: A synchronous reset loads SEED (default 1) into the register, whatever the mode and data inputs are.
- R2: With mode 2'b11 (storage) the register takes dataIn at each clock edge.
- R3: With mode 2'b10 (generator) a nonzero state s becomes (s<<1 masked to WIDTH) XOR {TAPS[WIDTH-1:1],1'b1} if s[WIDTH-1] is 1, and plain s<<1 otherwise. dataIn has no effect on the result.
- R4: In generator mode, starting from the reset seed 1, the state first returns to 1 after exactly 2^WIDTH − 1 clocks. This holds for WIDTH 4 with taps 4'b0010 and for WIDTH 8 with taps 8'b00011100.
- R5: In generator mode an all-zero state becomes 1 at the next edge, and the state is never zero after a generator step.
- R6: With mode 2'b01 (compactor) the next state is the generator step of R3 XOR dataIn, with no zero correction. Zero state with zero input stays zero, and a stream of words gives the signature of a software model.
- R7: With mode 2'b00 (scan) the next state is {state[WIDTH-2:0], scanIn}. scanOut always equals state[WIDTH-1] in every mode, so a signature leaves most-significant bit first.
- R8: The mode sampled at a clock edge decides that edge's update, so a mode change acts on the very next edge with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 scan, 01 compactor, 10 generator, 11 storage |
| dataIn | input | WIDTH | Parallel data / response word |
| scanIn | input | 1 | Serial input to stage 0 |
| dataOut | output | WIDTH | Parallel register contents |
| scanOut | output | 1 | Last stage of the register |

## Verification
The all-zero state is the hardest case to reach from the ports. A seeded generator never reaches it. The stimulus gets there in two ways: by loading zero in storage mode before switching to the generator, and by folding a word equal to the step result in compactor mode. Full-period runs of 255 and 15 clocks at the two widths check the maximal-length claim. A randomly mixed mode stream checks that every mode change acts on the next edge.

// File: rtl/bistreg_pkg.sv
package bistreg_pkg;

  typedef enum logic [1:0] {
    MODE_SCAN = 2'b00,
    MODE_FOLD = 2'b01,
    MODE_GEN  = 2'b10,
    MODE_HOLD = 2'b11
  } bistMode_e;

  typedef struct packed {
    logic loadPar;
    logic shiftSerial;
    logic feedbackEn;
    logic foldData;
    logic zeroGuard;
  } bistStrobe_t;

endpackage

// File: rtl/bistreg_ctrl.sv
module bistreg_ctrl
  import bistreg_pkg::*;
(
  input  logic [1:0]  modeSel,
  output bistStrobe_t strb
);

  bistMode_e modeE;
  assign modeE = bistMode_e'(modeSel);

  always_comb begin
    strb = '0;
    case (modeE)
      MODE_SCAN: strb.shiftSerial = 1'b1;
      MODE_FOLD: begin
        strb.feedbackEn = 1'b1;
        strb.foldData   = 1'b1;
      end
      MODE_GEN: begin
        strb.feedbackEn = 1'b1;
        strb.zeroGuard  = 1'b1;
      end
      MODE_HOLD: strb.loadPar = 1'b1;
      default:   strb = '0;
    endcase
  end

endmodule

// File: rtl/bistreg_dp.sv
module bistreg_dp
  import bistreg_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'b0001_1100,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  bistStrobe_t      strb,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             scanIn,
  output logic [WIDTH-1:0] stateOut
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] stateD;
  logic [WIDTH-1:0] chainBit;
  logic             fbBit;
  logic             stateZero;

  assign fbBit     = strb.feedbackEn & stateQ[TOP];
  assign stateZero = (stateQ == '0);

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_stage
    if (gi == 0) begin : g_head
      assign chainBit[gi] = strb.shiftSerial ? scanIn
                          : (fbBit | (strb.zeroGuard & stateZero));
    end else begin : g_body
      assign chainBit[gi] = stateQ[gi-1] ^ (TAPS[gi] & fbBit);
    end
    assign stateD[gi] = strb.loadPar ? dataIn[gi]
                      : (chainBit[gi] ^ (strb.foldData & dataIn[gi]));
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= SEED;
    else     stateQ <= stateD;
  end

  assign stateOut = stateQ;

endmodule

// File: rtl/bistreg_top.sv
module bistreg_top
  import bistreg_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'b0001_1100,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             scanIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             scanOut
);

  bistStrobe_t strb;
  logic [WIDTH-1:0] stateOut;

  bistreg_ctrl u_ctrl (
    .modeSel (mode),
    .strb    (strb)
  );

  bistreg_dp #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .dataIn   (dataIn),
    .scanIn   (scanIn),
    .stateOut (stateOut)
  );

  assign dataOut = stateOut;
  assign scanOut = stateOut[WIDTH-1];

endmodule

// File: rtl/bistreg_chk.sv
module bistreg_chk #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'b0001_1100,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] dataIn,
  input logic             scanIn,
  input logic [WIDTH-1:0] dataOut,
  input logic             scanOut
);

  localparam logic [WIDTH-1:0] RED = {TAPS[WIDTH-1:1], 1'b1};

  function automatic logic [WIDTH-1:0] mulX(input logic [WIDTH-1:0] s);
    return s[WIDTH-1] ? ((s << 1) ^ RED) : (s << 1);
  endfunction

  // R1
  p_reset_seed_r1: assert property (@(posedge clk) rst |=> dataOut == SEED);

  // R2
  p_hold_load_r2: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |=> dataOut == $past(dataIn));

  // R3
  p_gen_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && dataOut != '0) |=> dataOut == mulX($past(dataOut)));

  // R5
  p_gen_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b10 |=> dataOut != '0);

  // R6
  p_fold_step_r6: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |=> dataOut == (mulX($past(dataOut)) ^ $past(dataIn)));

  // R7
  p_scan_shift_r7: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> (dataOut[0] == $past(scanIn)) && (scanOut == $past(dataOut[WIDTH-2])));

endmodule

bind bistreg_top bistreg_chk #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode),
  .dataIn  (dataIn),
  .scanIn  (scanIn),
  .dataOut (dataOut),
  .scanOut (scanOut)
);

// File: tb/tb_bistreg_top.sv
module tb_bistreg_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b11, mode4 = 2'b11;
  logic [7:0] din = '0;
  logic [3:0] din4 = '0;
  logic si = 1'b0, si4 = 1'b0;
  logic [7:0] dout;
  logic [3:0] dout4;
  logic so, so4;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] exp8, exp4;

  always #(CLK_PERIOD/2) clk = ~clk;

  bistreg_top dut (.clk(clk), .rst(rst), .mode(mode), .dataIn(din),
    .scanIn(si), .dataOut(dout), .scanOut(so));

  bistreg_top #(.WIDTH(4), .TAPS(4'b0010), .SEED(4'h1)) dut4 (.clk(clk), .rst(rst),
    .mode(mode4), .dataIn(din4), .scanIn(si4), .dataOut(dout4), .scanOut(so4));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Reference model: w = width, red = low part of the polynomial
  function automatic logic [7:0] model(input int w, input logic [7:0] red,
      input logic [1:0] m, input logic [7:0] s, input logic [7:0] d, input logic sIn);
    logic [7:0] mask, t;
    mask = 8'((1 << w) - 1);
    t = ((s << 1) & mask) ^ (s[w-1] ? red : 8'h00);
    case (m)
      2'b00: return ((s << 1) | {7'b0, sIn}) & mask;
      2'b01: return (t ^ d) & mask;
      2'b10: return (s == 0) ? 8'h01 : t;
      default: return d & mask;
    endcase
  endfunction

  function automatic string tagOf(input logic [1:0] m);
    case (m)
      2'b00: return "R7";
      2'b01: return "R6";
      2'b10: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic doReset;
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    exp8 = 8'h01; exp4 = 8'h01;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick();
    // R1: reset with storage mode and all-ones data still gives the seed
    din = 8'hFF; din4 = 4'hF;
    doReset();
    chk("R1 seed w8", dout, 8'h01);
    chk("R1 seed w4", dout4, 4'h1);

    // R8 / R2 / R3 directed mode switch
    mode = 2'b11; din = 8'h5A; tick();
    chk("R2 load", dout, 8'h5A);
    mode = 2'b10; din = 8'hFF; tick();
    chk("R8 switch to generator, R3 ignore data", dout, model(8, 8'h1D, 2'b10, 8'h5A, 8'h00, 1'b0));

    // R5: zero state in generator mode
    mode = 2'b11; din = 8'h00; mode4 = 2'b11; din4 = 4'h0; tick();
    mode = 2'b10; mode4 = 2'b10; din = 8'hC3; tick();
    chk("R5 zero escape w8", dout, 8'h01);
    chk("R5 zero escape w4", dout4, 4'h1);

    // R6: compactor zero with zero data stays zero
    mode = 2'b11; din = 8'h00; tick();
    mode = 2'b01; din = 8'h00; tick();
    chk("R6 fold zero stays zero", dout, 8'h00);
    // fold 0x80 so step result 0x1D xor data 0x1D gives zero
    mode = 2'b11; din = 8'h80; tick();
    mode = 2'b01; din = 8'h1D; tick();
    chk("R6 fold reaches zero", dout, 8'h00);
    chk("R7 scanOut at zero", so, 1'b0);

    // Random mixed stream
    doReset();
    for (int k = 0; k < 600; k++) begin
      mode = 2'($urandom); din = 8'($urandom); si = 1'($urandom);
      mode4 = 2'($urandom); din4 = 4'($urandom); si4 = 1'($urandom);
      exp8 = model(8, 8'h1D, mode, exp8, din, si);
      exp4 = model(4, 8'h03, mode4, exp4, {4'b0, din4}, si4);
      tick();
      chk({tagOf(mode), " R8 random w8"}, dout, exp8);
      chk({tagOf(mode4), " R8 random w4"}, dout4, exp4[3:0]);
      chk("R7 scanOut w8", so, exp8[7]);
      chk("R7 scanOut w4", so4, exp4[3]);
    end

    // R6 signature then R7 readout
    doReset();
    mode = 2'b01;
    for (int k = 0; k < 64; k++) begin
      din = 8'($urandom);
      exp8 = model(8, 8'h1D, 2'b01, exp8, din, 1'b0);
      tick();
    end
    chk("R6 signature", dout, exp8);
    mode = 2'b00; si = 1'b0;
    for (int k = 7; k >= 0; k--) begin
      chk("R7 signature bit out", so, exp8[k]);
      tick();
    end
    chk("R7 shifted empty", dout, 8'h00);

    // R4: full period, both widths
    doReset();
    mode = 2'b10; mode4 = 2'b10;
    begin
      int cnt8 = 0, cnt4 = 0;
      for (int k = 0; k < 300; k++) begin
        exp8 = model(8, 8'h1D, 2'b10, exp8, 8'h00, 1'b0);
        exp4 = model(4, 8'h03, 2'b10, exp4, 8'h00, 1'b0);
        tick();
        if (dout !== exp8) chk("R3 period walk w8", dout, exp8);
        if (dout4 !== exp4[3:0]) chk("R3 period walk w4", dout4, exp4[3:0]);
        if (cnt8 == 0 && dout == 8'h01) cnt8 = k + 1;
        if (cnt4 == 0 && dout4 == 4'h1) cnt4 = k + 1;
        if (cnt8 != 0 && cnt4 != 0) break;
      end
      chk("R4 period w8", cnt8, 255);
      chk("R4 period w4", cnt4, 15);
    end

    // R1: reset mid-run overrides generator mode
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset mid-run", dout, 8'h01);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule